// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small processor core built around a single accumulator. Instructions and data share one 16-bit word format and one memory. Every instruction runs as a series of register-transfer steps, one step per clock. The transfers move words through the program counter, the memory address register, the memory buffer register, the instruction register and the accumulator. Each instruction begins with a four-step fetch. An optional three-step pointer cycle may follow it, and an execute phase of three or four steps completes it.

The core reaches memory through one synchronous word-addressed port. The address always comes from the memory address register, and write data always comes from the memory buffer register. Read data arrives one clock after a read strobe. The core supports load, store and add. Each of them has a direct form, which carries a 12-bit address field and so reaches 4K words. Each also has a pointer form, in which the field names a word holding a full 16-bit operand address, which reaches 64K words. A halt opcode stops the core. An unknown opcode also stops it and raises an error flag. The program counter and accumulator are visible at the ports. After reset the core starts fetching from a fixed address.

Top module: `acc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, pcOut is RESET_PC (0x300 by default), acOut is 0, halted and error are 0, and memRe and memWe are 0.
- R2: The opcode sits in instruction bits 15:12 and the address field in bits 11:0. The opcodes are 0x1 load, 0x2 store, 0x3 add (direct) and 0x5 load, 0x6 store, 0x7 add (pointer form), so opcode bit 14 marks the pointer form. 0xF is halt, and every other value is undefined.
- R3: The fetch takes four cycles. Its second cycle raises memRe with memAddr equal to pcOut. The program counter advances by exactly one at the end of the fourth cycle and changes at no other time.
- R4: In the pointer forms, a three-cycle pointer phase follows the fetch. Its second cycle reads memAddr equal to the zero-extended address field. The whole 16-bit word returned becomes the operand address.
- R5: The load and add execute phases take four cycles. Their second cycle reads the operand address. The accumulator takes the word (load) or the 16-bit sum of itself and the word, carry dropped (add), at the end of the fourth cycle. It never changes at any other time.
- R6: The store execute phase takes three cycles. Its third cycle raises memWe for one cycle, with memAddr equal to the operand address and memWrData equal to the accumulator.
- R7: After fetching a halt, the core stays halted. pcOut is the halt address plus one, error is 0, and memRe and memWe stay low until reset.
- R8: After fetching an undefined opcode, the core halts with error set to 1 and performs no further memory access.
- R9: Consider this program: load from 0x941 at 0x300, pointer-form add through 0x500 (which holds 0x942) at 0x301, and store to 0x941 at 0x302. With 0x941 holding 0x0941 and 0x942 holding 0x0942, the program ends with 0x941 holding 0x1283. The next instruction is then fetched from 0x303.
- R10: memRe and memWe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 16 | Memory word address (memory address register) |
| memRe | output | 1 | Read strobe; data returns on memRdData one cycle later |
| memWe | output | 1 | Write strobe for memWrData at memAddr |
| memWrData | output | 16 | Write data (memory buffer register) |
| memRdData | input | 16 | Read data from memory |
| pcOut | output | 16 | Program counter |
| acOut | output | 16 | Accumulator |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Core stopped on an undefined opcode |

## Verification
The core is tried with four programs. The first is the three-instruction fragment, whose single sum shows that the pointer word, not the field, selects the add operand. The second mixes all three pointer forms with direct ones. It places an add whose sum wraps past 0xFFFF and a store to the top word of the 4K direct range, which separates zero-extension and carry handling from a plain copy. Two further programs hit an undefined opcode, once after a load and once as the very first word. These show that the error halt keeps the accumulator, quiets the memory port, and differs from a normal halt. For every program, each memory strobe and the cycle of the halt are compared against a step-by-step model of the instruction set.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  typedef enum logic [3:0] {
    ST_F1, ST_F2, ST_F3, ST_F4,
    ST_I1, ST_I2, ST_I3,
    ST_E1, ST_E2, ST_E3, ST_E4,
    ST_HALT
  } stepT;

  typedef struct packed {
    logic marFromPc;
    logic marFromField;
    logic marFromPtr;
    logic memRead;
    logic memWrite;
    logic mbrFromMem;
    logic mbrFromAc;
    logic irFromMbr;
    logic pcInc;
    logic acLoad;
    logic acAdd;
  } strobeT;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD   = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE  = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD    = 4'h3;
  localparam logic [OP_W-1:0] OP_LOADP  = 4'h5;
  localparam logic [OP_W-1:0] OP_STOREP = 4'h6;
  localparam logic [OP_W-1:0] OP_ADDP   = 4'h7;
  localparam logic [OP_W-1:0] OP_HALT   = 4'hF;

  function automatic logic opIsPtr(logic [OP_W-1:0] op);
    return (op == OP_LOADP) || (op == OP_STOREP) || (op == OP_ADDP);
  endfunction

  function automatic logic opIsMemOp(logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) || opIsPtr(op);
  endfunction

  function automatic logic [OP_W-1:0] opBase(logic [OP_W-1:0] op);
    return op & 4'b1011;
  endfunction

endpackage

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] mbrOp,
  input  logic [OP_W-1:0] irOp,
  output strobeT          strobe,
  output logic            halted,
  output logic            error
);

  stepT step, stepNext;
  logic errNext;
  logic irStore, irLoad;

  assign irStore = (opBase(irOp) == OP_STORE);
  assign irLoad  = (opBase(irOp) == OP_LOAD);

  always_comb begin
    strobe   = '0;
    stepNext = step;
    errNext  = error;
    unique case (step)
      ST_F1: begin strobe.marFromPc = 1'b1; stepNext = ST_F2; end
      ST_F2: begin strobe.memRead = 1'b1; stepNext = ST_F3; end
      ST_F3: begin strobe.mbrFromMem = 1'b1; stepNext = ST_F4; end
      ST_F4: begin
        strobe.irFromMbr = 1'b1;
        strobe.pcInc     = 1'b1;
        if (!opIsMemOp(mbrOp)) begin
          stepNext = ST_HALT;
          errNext  = (mbrOp != OP_HALT);
        end else if (opIsPtr(mbrOp)) begin
          stepNext = ST_I1;
        end else begin
          stepNext = ST_E1;
        end
      end
      ST_I1: begin strobe.marFromField = 1'b1; stepNext = ST_I2; end
      ST_I2: begin strobe.memRead = 1'b1; stepNext = ST_I3; end
      ST_I3: begin strobe.mbrFromMem = 1'b1; stepNext = ST_E1; end
      ST_E1: begin
        if (opIsPtr(irOp)) strobe.marFromPtr = 1'b1;
        else               strobe.marFromField = 1'b1;
        stepNext = ST_E2;
      end
      ST_E2: begin
        if (irStore) strobe.mbrFromAc = 1'b1;
        else         strobe.memRead = 1'b1;
        stepNext = ST_E3;
      end
      ST_E3: begin
        if (irStore) begin
          strobe.memWrite = 1'b1;
          stepNext = ST_F1;
        end else begin
          strobe.mbrFromMem = 1'b1;
          stepNext = ST_E4;
        end
      end
      ST_E4: begin
        if (irLoad) strobe.acLoad = 1'b1;
        else        strobe.acAdd  = 1'b1;
        stepNext = ST_F1;
      end
      default: stepNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step  <= ST_F1;
      error <= 1'b0;
    end else begin
      step  <= stepNext;
      error <= errNext;
    end
  end

  assign halted = (step == ST_HALT);

  p_rw_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.memRead && strobe.memWrite));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!strobe.memRead && !strobe.memWrite));

  p_error_halts_r8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> halted);

  p_ptr_after_fetch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_F4 && opIsPtr(mbrOp)) |=> (step == ST_I1));

endmodule

// File: rtl/acc_core_dpath.sv
module acc_core_dpath
  import acc_core_pkg::*;
#(
  parameter int            WORD_W   = 16,
  parameter logic [15:0]   RESET_PC = 16'h0300
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [WORD_W-1:0] memWrData,
  output logic [OP_W-1:0]   mbrOp,
  output logic [OP_W-1:0]   irOp,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] acOut
);

  localparam int FIELD_W = WORD_W - OP_W;

  logic [WORD_W-1:0] pc, mar, mbr, ac;
  logic [OP_W-1:0]   ir;
  logic [WORD_W-1:0] fieldAddr;

  assign fieldAddr = {{OP_W{1'b0}}, mbr[FIELD_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc  <= WORD_W'(RESET_PC);
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      if (strobe.marFromPc)         mar <= pc;
      else if (strobe.marFromField) mar <= fieldAddr;
      else if (strobe.marFromPtr)   mar <= mbr;

      if (strobe.mbrFromMem)        mbr <= memRdData;
      else if (strobe.mbrFromAc)    mbr <= ac;

      if (strobe.irFromMbr)         ir <= mbr[WORD_W-1 -: OP_W];
      if (strobe.pcInc)             pc <= pc + 1'b1;

      if (strobe.acLoad)            ac <= mbr;
      else if (strobe.acAdd)        ac <= ac + mbr;
    end
  end

  assign memAddr   = mar;
  assign memWrData = mbr;
  assign memRe     = strobe.memRead;
  assign memWe     = strobe.memWrite;
  assign mbrOp     = mbr[WORD_W-1 -: OP_W];
  assign irOp      = ir;
  assign pcOut     = pc;
  assign acOut     = ac;

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pc != $past(pc)) |-> (pc == $past(pc) + 1'b1));

  p_ac_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.acLoad && !strobe.acAdd) |=> $stable(ac));

  p_store_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWrite |-> (memWrData == ac));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int          WORD_W   = 16,
  parameter logic [15:0] RESET_PC = 16'h0300
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [WORD_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] acOut,
  output logic              halted,
  output logic              error
);

  strobeT          strobe;
  logic [OP_W-1:0] mbrOp, irOp;

  acc_core_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .mbrOp  (mbrOp),
    .irOp   (irOp),
    .strobe (strobe),
    .halted (halted),
    .error  (error)
  );

  acc_core_dpath #(
    .WORD_W   (WORD_W),
    .RESET_PC (RESET_PC)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memRe     (memRe),
    .memWe     (memWe),
    .memWrData (memWrData),
    .mbrOp     (mbrOp),
    .irOp      (irOp),
    .pcOut     (pcOut),
    .acOut     (acOut)
  );

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr, memWrData, pcOut, acOut;
  logic [15:0] memRdData = '0;
  logic        memRe, memWe, halted, error;

  always #4 clk = ~clk;

  acc_core uut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWrData(memWrData), .memRdData(memRdData), .pcOut(pcOut), .acOut(acOut),
    .halted(halted), .error(error)
  );

  // behavioural memory and shadow image for the model
  logic [15:0] bmem [0:4095];
  logic [15:0] smem [0:4095];

  always @(posedge clk) begin
    if (memWe) bmem[memAddr[11:0]] <= memWrData;
    if (memRe) memRdData <= bmem[memAddr[11:0]];
  end

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [15:0] data;
    int          kind;   // 0 fetch, 1 pointer, 2 operand read, 3 write
    logic [15:0] pc;
    logic [15:0] ac;
  } accT;

  accT         expQ[$];
  int          expCycles;
  logic [15:0] expPc, expAc, lastFetchPc;
  logic        expErr;
  int          checks = 0, errors = 0;
  int          posCount = 0;
  bit          active = 0, seenHalt = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) posCount <= 0;
    else       posCount <= posCount + 1;
  end

  always @(negedge clk) begin
    if (rstN && active) begin
      check(!(memRe && memWe), "R10", {memRe, memWe}, 0);
      if (memRe || memWe) begin
        if (expQ.size() == 0) begin
          check(0, "R7 R8 access after halt", memAddr, 0);
        end else begin
          accT e;
          e = expQ.pop_front();
          case (e.kind)
            0: begin
              check(memRe && memAddr == e.addr, "R3 fetch address", memAddr, e.addr);
              check(pcOut == e.pc, "R3 pc at fetch", pcOut, e.pc);
              check(acOut == e.ac, "R5 ac before instruction", acOut, e.ac);
              lastFetchPc = pcOut;
            end
            1: check(memRe && memAddr == e.addr, "R4 pointer read", memAddr, e.addr);
            2: check(memRe && memAddr == e.addr, "R5 operand read", memAddr, e.addr);
            default: check(memWe && memAddr == e.addr && memWrData == e.data,
                           "R6 store", {memAddr, memWrData}, {e.addr, e.data});
          endcase
        end
      end
      if (halted && !seenHalt) begin
        seenHalt = 1;
        check(posCount == expCycles, "R3 R4 R5 R6 cycle of halt", posCount, expCycles);
        check(pcOut == expPc, "R7 pc at halt", pcOut, expPc);
        check(acOut == expAc, "R5 ac at halt", acOut, expAc);
        check(error == expErr, "R8 error flag", error, expErr);
      end
    end
  end

  task automatic runModel();
    logic [15:0] pc, ac, ir, ea;
    logic [3:0]  op;
    int          cyc;
    bit          done;
    pc = 16'h0300; ac = '0; cyc = 0; done = 0;
    expQ.delete();
    while (!done && cyc < 100000) begin
      expQ.push_back('{pc, 1'b0, 16'h0, 0, pc, ac});
      ir = smem[pc[11:0]];
      pc = pc + 16'd1;
      cyc += 4;
      op = ir[15:12];
      ea = {4'h0, ir[11:0]};
      case (op)
        4'h1, 4'h2, 4'h3: ;
        4'h5, 4'h6, 4'h7: begin
          expQ.push_back('{ea, 1'b0, 16'h0, 1, 16'h0, 16'h0});
          ea = smem[ea[11:0]];
          cyc += 3;
        end
        4'hF: begin done = 1; expErr = 0; end
        default: begin done = 1; expErr = 1; end
      endcase
      if (!done) begin
        if (op == 4'h2 || op == 4'h6) begin
          smem[ea[11:0]] = ac;
          expQ.push_back('{ea, 1'b1, ac, 3, 16'h0, 16'h0});
          cyc += 3;
        end else begin
          expQ.push_back('{ea, 1'b0, 16'h0, 2, 16'h0, 16'h0});
          if (op == 4'h1 || op == 4'h5) ac = smem[ea[11:0]];
          else                          ac = ac + smem[ea[11:0]];
          cyc += 4;
        end
      end
    end
    expCycles = cyc;
    expPc = pc;
    expAc = ac;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) begin
      bmem[i] = '0;
      smem[i] = '0;
    end
  endtask

  task automatic poke(int a, logic [15:0] v);
    bmem[a] = v;
    smem[a] = v;
  endtask

  task automatic runProgram();
    int wd;
    int bad;
    logic [15:0] pcHalt;
    active = 0;
    seenHalt = 0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pcOut == 16'h0300, "R1 pc", pcOut, 16'h0300);
    check(acOut == 16'h0 && !halted && !error, "R1 ac/halted/error",
          {acOut, halted, error}, 0);
    check(!memRe && !memWe, "R1 strobes", {memRe, memWe}, 0);
    runModel();
    active = 1;
    rstN = 1'b1;
    wd = 0;
    while (!seenHalt && wd < 5000) begin
      @(negedge clk);
      wd++;
    end
    if (!seenHalt) check(0, "watchdog", wd, 5000);
    pcHalt = pcOut;
    repeat (10) @(negedge clk);
    check(pcOut == pcHalt && halted, "R7 stays halted", pcOut, pcHalt);
    check(expQ.size() == 0, "R3 R4 R5 R6 all accesses seen", expQ.size(), 0);
    bad = 0;
    for (int i = 0; i < 4096; i++) if (bmem[i] !== smem[i]) bad++;
    check(bad == 0, "R6 memory image", bad, 0);
  endtask

  initial begin
    // program 1: the three-instruction fragment (R9)
    clearMem();
    poke('h300, 16'h1941);
    poke('h301, 16'h7500);
    poke('h302, 16'h2941);
    poke('h303, 16'hF000);
    poke('h500, 16'h0942);
    poke('h941, 16'h0941);
    poke('h942, 16'h0942);
    runProgram();
    check(bmem['h941] == 16'h1283, "R9 result word", bmem['h941], 16'h1283);
    check(lastFetchPc == 16'h0303, "R9 next fetch", lastFetchPc, 16'h0303);
    check(pcOut == 16'h0304 && !error, "R7 halt pc", pcOut, 16'h0304);

    // program 2: pointer forms, add wrap, top of direct range (R2 R4 R5 R6)
    clearMem();
    poke('h300, 16'h5400);
    poke('h301, 16'h3401);
    poke('h302, 16'h6402);
    poke('h303, 16'h7403);
    poke('h304, 16'h2FFF);
    poke('h305, 16'hF000);
    poke('h400, 16'h0A10);
    poke('h401, 16'h0002);
    poke('h402, 16'h0B20);
    poke('h403, 16'h0B20);
    poke('hA10, 16'hFFFF);
    runProgram();
    check(bmem['hB20] == 16'h0001, "R2 R4 pointer store with wrapped sum", bmem['hB20], 16'h0001);
    check(bmem['hFFF] == 16'h0002, "R2 direct store at top of field", bmem['hFFF], 16'h0002);
    check(acOut == 16'h0002, "R5 final ac", acOut, 16'h0002);

    // program 3: undefined opcode after a load (R8)
    clearMem();
    poke('h300, 16'h1941);
    poke('h301, 16'h9000);
    poke('h941, 16'h1234);
    runProgram();
    check(error && halted && acOut == 16'h1234, "R8 undefined after load",
          {error, halted, acOut}, {2'b11, 16'h1234});

    // program 4: undefined opcode as the first word (R8)
    clearMem();
    poke('h300, 16'h0123);
    runProgram();
    check(error && pcOut == 16'h0301 && acOut == 16'h0, "R8 undefined first",
          {error, pcOut}, {1'b1, 16'h0301});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    check(0, "watchdog global", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule